// File: doc/BRIEF.md
# Multi-Device Read Latency Aligner

Several memory devices return read data on separate lanes. After calibration each lane has its own measured latency, counted in controller cycles from the read request to the data. This block gives every lane a small circular buffer. It then delays each lane by the gap between that lane's latency and a common reference. The result is one wide read word in which all lanes belong to the same request, together with a single valid flag.

The reference latency depends on the mode. In automatic mode it is the largest measured latency. In fixed mode it is a target supplied by the user. The delay is not built from register stages. Every lane writes its buffer once per cycle, and the buffer is read at the write pointer minus a per-lane offset.

Calibration results are taken in on a single load strobe. At that point the block also reports two things: whether the requested fixed target can be met, and whether the measured spread is too wide to align in automatic mode. When the configuration is unusable, valid is held low.

Top module: `rd_lat_align`

## Requirements
- R1: After synchronous reset, `rvalid_o`, `lat_ok_o` and `spread_err_o` are low and `rdata_o` is all zeros.
- R2: A word presented to device lane d in cycle c reaches `rdata_o` after the clock edge c + 2 + REF − L_d. Here L_d is the lane's loaded latency and REF is the reference latency.
- R3: In automatic mode (`fixed_mode_i` = 0 at load), REF is the largest of the loaded lane latencies.
- R4: In fixed mode (`fixed_mode_i` = 1 at load), REF is the loaded `target_i`.
- R5: `lat_ok_o` is high only when fixed mode was loaded and the target meets two conditions. The target is at least the largest lane latency, and target minus the smallest lane latency is at most DEPTH − 1. In automatic mode `lat_ok_o` is low.
- R6: `spread_err_o` is high only when automatic mode was loaded and the largest minus the smallest lane latency exceeds MAX_SPREAD (default 2).
- R7: `rvalid_o` is high only when the aligned entries of all lanes carry a valid strobe and the loaded configuration is usable. Usable means no spread error in automatic mode, and an achievable target in fixed mode.
- R8: `rdata_o` is the concatenation of the lane words, with lane 0 in bits DW−1:0 and lane k in bits (k+1)·DW−1 : k·DW.
- R9: `lat_i`, `target_i` and `fixed_mode_i` are sampled only in a cycle where `load_i` is high. At any other time, changing them does not affect the flags or the alignment.
- R10: Until the first load after reset, `rvalid_o` stays low whatever the lane inputs do.
- R11: `rdata_o` changes only together with a valid beat and otherwise holds the last merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| wdata_i | input | NUM_DEV*DW | Per-lane read words, lane 0 in the low bits |
| wvalid_i | input | NUM_DEV | Per-lane word strobe |
| lat_i | input | NUM_DEV*LAT_W | Per-lane measured latency, lane 0 in the low bits |
| load_i | input | 1 | Strobe that captures latencies, mode and target |
| fixed_mode_i | input | 1 | 1 selects fixed-target mode, 0 selects automatic mode |
| target_i | input | LAT_W | Requested fixed latency |
| rdata_o | output | NUM_DEV*DW | Merged, aligned read word |
| rvalid_o | output | 1 | Merged word valid |
| lat_ok_o | output | 1 | Requested fixed latency is achievable |
| spread_err_o | output | 1 | Automatic-mode latency spread too wide |

## Verification
The bench builds the block with three lanes of 8 bits, a depth of 8 and 5-bit latencies. With three lanes, the largest and smallest latencies can sit on different lanes while a third lane lies between them. Each lane's word is unique per request and per lane, so any misplaced offset or swapped lane position shows up as a data mismatch. A depth of 8 makes both edges of the fixed-target window reachable with small latencies: a reach of exactly 7 is accepted and a reach of 8 is rejected. The bench also covers the automatic spread limit at 2 and at 3, and a beat dropped on one lane only.

// File: rtl/rla_pkg.sv
package rla_pkg;

  typedef enum logic {
    MODE_AUTO  = 1'b0,
    MODE_FIXED = 1'b1
  } lat_mode_e;

endpackage

// File: rtl/rla_cfg.sv
// Latches calibration results on the load strobe and derives per-lane
// read-pointer offsets plus the usability flags.
module rla_cfg
  import rla_pkg::*;
#(
  parameter int NUM_DEV    = 2,
  parameter int LAT_W      = 5,
  parameter int DEPTH      = 8,
  parameter int PTR_W      = 3,
  parameter int MAX_SPREAD = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_i,
  input  lat_mode_e                mode_i,
  input  logic [LAT_W-1:0]         target_i,
  input  logic [NUM_DEV*LAT_W-1:0] lat_i,
  output logic [NUM_DEV*PTR_W-1:0] off_o,
  output logic                     good_o,
  output logic                     lat_ok_o,
  output logic                     err_o
);

  localparam logic [LAT_W:0] REACH_MAX  = (LAT_W+1)'(DEPTH - 1);
  localparam logic [LAT_W:0] SPREAD_LIM = (LAT_W+1)'(MAX_SPREAD);

  logic [LAT_W-1:0]         lat_max, lat_min, ref_lat;
  logic [LAT_W:0]           spread, reach;
  logic                     fix_ok, auto_err;
  logic [NUM_DEV*PTR_W-1:0] off_n;

  // Largest and smallest lane latency.
  always_comb begin
    lat_max = lat_i[LAT_W-1:0];
    lat_min = lat_i[LAT_W-1:0];
    for (int d = 1; d < NUM_DEV; d++) begin
      if (lat_i[d*LAT_W +: LAT_W] > lat_max) lat_max = lat_i[d*LAT_W +: LAT_W];
      if (lat_i[d*LAT_W +: LAT_W] < lat_min) lat_min = lat_i[d*LAT_W +: LAT_W];
    end
  end

  always_comb begin
    spread   = {1'b0, lat_max} - {1'b0, lat_min};
    reach    = {1'b0, target_i} - {1'b0, lat_min};
    auto_err = (spread > SPREAD_LIM);
    fix_ok   = (target_i >= lat_max) && (reach <= REACH_MAX);
    ref_lat  = (mode_i == MODE_FIXED) ? target_i : lat_max;
  end

  // Offset of each lane = reference minus own latency (modulo buffer size).
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_off
    assign off_n[d*PTR_W +: PTR_W] = PTR_W'(ref_lat - lat_i[d*LAT_W +: LAT_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_o    <= '0;
      good_o   <= 1'b0;
      lat_ok_o <= 1'b0;
      err_o    <= 1'b0;
    end else if (load_i) begin
      off_o    <= off_n;
      if (mode_i == MODE_FIXED) begin
        good_o   <= fix_ok;
        lat_ok_o <= fix_ok;
        err_o    <= 1'b0;
      end else begin
        good_o   <= !auto_err;
        lat_ok_o <= 1'b0;
        err_o    <= auto_err;
      end
    end
  end

endmodule

// File: rtl/rla_buf.sv
// One lane buffer: written every cycle at a free-running pointer, read at
// the pointer minus the lane offset. Data lives in an inferable RAM; the
// valid bits are resettable flops so stale RAM content is never flagged.
module rla_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    wdata_i,
  input  logic             wvalid_i,
  input  logic [PTR_W-1:0] off_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o
);

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vbits;
  logic [PTR_W-1:0] wp, rd_addr;

  assign rd_addr = wp - PTR_W'(1) - off_i;

  // RAM port: write-first address, registered read (read-before-write).
  always_ff @(posedge clk) begin
    mem[wp] <= wdata_i;
    rdata_o <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      vbits    <= '0;
      rvalid_o <= 1'b0;
    end else begin
      wp        <= wp + PTR_W'(1);
      vbits[wp] <= wvalid_i;
      rvalid_o  <= vbits[rd_addr];
    end
  end

endmodule

// File: rtl/rla_merge.sv
// Combines the aligned lane outputs into one registered word and flag.
module rla_merge #(
  parameter int NUM_DEV = 2,
  parameter int DW      = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  good_i,
  input  logic [NUM_DEV*DW-1:0] bdata_i,
  input  logic [NUM_DEV-1:0]    bvalid_i,
  output logic [NUM_DEV*DW-1:0] rdata_o,
  output logic                  rvalid_o
);

  logic beat;

  assign beat = good_i && (&bvalid_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= beat;
      if (beat) rdata_o <= bdata_i;
    end
  end

endmodule

// File: rtl/rd_lat_align.sv
// Top: per-lane buffers aligned to a common read latency.
// DEPTH must be a power of two and $clog2(DEPTH) must not exceed LAT_W.
module rd_lat_align
  import rla_pkg::*;
#(
  parameter int NUM_DEV    = 2,
  parameter int DW         = 16,
  parameter int DEPTH      = 8,
  parameter int LAT_W      = 5,
  parameter int MAX_SPREAD = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_DEV*DW-1:0]    wdata_i,
  input  logic [NUM_DEV-1:0]       wvalid_i,
  input  logic [NUM_DEV*LAT_W-1:0] lat_i,
  input  logic                     load_i,
  input  logic                     fixed_mode_i,
  input  logic [LAT_W-1:0]         target_i,
  output logic [NUM_DEV*DW-1:0]    rdata_o,
  output logic                     rvalid_o,
  output logic                     lat_ok_o,
  output logic                     spread_err_o
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [NUM_DEV*PTR_W-1:0] off;
  logic                     good;
  logic [NUM_DEV*DW-1:0]    buf_d;
  logic [NUM_DEV-1:0]       buf_v;

  rla_cfg #(
    .NUM_DEV   (NUM_DEV),
    .LAT_W     (LAT_W),
    .DEPTH     (DEPTH),
    .PTR_W     (PTR_W),
    .MAX_SPREAD(MAX_SPREAD)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .mode_i  (lat_mode_e'(fixed_mode_i)),
    .target_i(target_i),
    .lat_i   (lat_i),
    .off_o   (off),
    .good_o  (good),
    .lat_ok_o(lat_ok_o),
    .err_o   (spread_err_o)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_lane
    rla_buf #(
      .DW   (DW),
      .DEPTH(DEPTH),
      .PTR_W(PTR_W)
    ) u_buf (
      .clk     (clk),
      .rst     (rst),
      .wdata_i (wdata_i[d*DW +: DW]),
      .wvalid_i(wvalid_i[d]),
      .off_i   (off[d*PTR_W +: PTR_W]),
      .rdata_o (buf_d[d*DW +: DW]),
      .rvalid_o(buf_v[d])
    );
  end

  rla_merge #(
    .NUM_DEV(NUM_DEV),
    .DW     (DW)
  ) u_merge (
    .clk     (clk),
    .rst     (rst),
    .good_i  (good),
    .bdata_i (buf_d),
    .bvalid_i(buf_v),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o)
  );

endmodule

// File: rtl/rla_chk.sv
module rla_chk #(
  parameter int NUM_DEV = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               load_i,
  input logic               fixed_mode_i,
  input logic               rvalid_o,
  input logic               lat_ok_o,
  input logic               spread_err_o,
  input logic [NUM_DEV-1:0] buf_valid
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rvalid_o && !lat_ok_o && !spread_err_o); // R1

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(lat_ok_o && spread_err_o)); // R5

  AST_FLAGS_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    !$past(load_i) |-> $stable(lat_ok_o) && $stable(spread_err_o)); // R9

  AST_OK_FROM_FIXED: assert property (@(posedge clk) disable iff (rst)
    $rose(lat_ok_o) |-> $past(load_i && fixed_mode_i)); // R5

  AST_ERR_FROM_AUTO: assert property (@(posedge clk) disable iff (rst)
    $rose(spread_err_o) |-> $past(load_i && !fixed_mode_i)); // R6

  AST_VALID_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
    rvalid_o |-> $past(&buf_valid)); // R7

  AST_ERR_BLOCKS_VALID: assert property (@(posedge clk) disable iff (rst)
    spread_err_o && $past(spread_err_o) |-> !rvalid_o); // R7

endmodule

bind rd_lat_align rla_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .load_i      (load_i),
  .fixed_mode_i(fixed_mode_i),
  .rvalid_o    (rvalid_o),
  .lat_ok_o    (lat_ok_o),
  .spread_err_o(spread_err_o),
  .buf_valid   (buf_v)
);

// File: tb/tb_rd_lat_align.sv
module tb_rd_lat_align;

  localparam int NDEV  = 3;
  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int LW    = 5;
  localparam int WIN   = 12;
  localparam logic [WIN-1:0] ISSUE = 12'b1011_0111_1101;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NDEV*DW-1:0]   wdata_i = '0;
  logic [NDEV-1:0]      wvalid_i = '0;
  logic [NDEV*LW-1:0]   lat_i = '0;
  logic                 load_i = 1'b0;
  logic                 fixed_mode_i = 1'b0;
  logic [LW-1:0]        target_i = '0;
  logic [NDEV*DW-1:0]   rdata_o;
  logic                 rvalid_o, lat_ok_o, spread_err_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  rd_lat_align #(
    .NUM_DEV(NDEV), .DW(DW), .DEPTH(DEPTH), .LAT_W(LW), .MAX_SPREAD(2)
  ) dut (
    .clk(clk), .rst(rst), .wdata_i(wdata_i), .wvalid_i(wvalid_i),
    .lat_i(lat_i), .load_i(load_i), .fixed_mode_i(fixed_mode_i),
    .target_i(target_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .lat_ok_o(lat_ok_o), .spread_err_o(spread_err_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cyc > 100000);
    errors++;
    $display("FAIL watchdog: act cycle %0d exp below 100000", cyc);
    finish_run();
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act %h exp %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int t, input int d);
    return DW'((t << 4) | (d + 1));
  endfunction

  // Loads a configuration, flushes, then streams WIN request slots and
  // checks every output cycle against the model.
  task automatic run_case(input string name, input bit fixed, input int tgt,
                          input int l0, input int l1, input int l2,
                          input int drop, input bit exp_ok, input bit exp_err);
    int lat [NDEV];
    int mx, rf, t;
    bit good, expv;
    logic [NDEV*DW-1:0] expw, lastw;
    lat[0] = l0; lat[1] = l1; lat[2] = l2;
    mx = l0;
    for (int d = 1; d < NDEV; d++) if (lat[d] > mx) mx = lat[d];
    rf = fixed ? tgt : mx;
    good = fixed ? exp_ok : !exp_err;
    @(negedge clk);
    for (int d = 0; d < NDEV; d++) lat_i[d*LW +: LW] = LW'(lat[d]);
    fixed_mode_i = fixed;
    target_i = LW'(tgt);
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    // R9: junk on config inputs without a load
    lat_i = '1;
    fixed_mode_i = !fixed;
    target_i = '0;
    check(lat_ok_o == exp_ok, "R5", {name, " lat_ok"}, 32'(lat_ok_o), 32'(exp_ok));
    check(spread_err_o == exp_err, "R6", {name, " spread_err"}, 32'(spread_err_o), 32'(exp_err));
    wvalid_i = '0;
    repeat (DEPTH + 4) @(negedge clk);
    lastw = rdata_o;
    for (int i = 0; i < WIN + rf + 5; i++) begin
      for (int d = 0; d < NDEV; d++) begin
        t = i - lat[d];
        if (t >= 0 && t < WIN && ISSUE[t] && !(d == 1 && t == drop)) begin
          wvalid_i[d] = 1'b1;
          wdata_i[d*DW +: DW] = pat(t, d);
        end else begin
          wvalid_i[d] = 1'b0;
          wdata_i[d*DW +: DW] = ~pat(i, d);
        end
      end
      t = i - rf - 3;
      expv = good && t >= 0 && t < WIN && ISSUE[t] && t != drop;
      // R2 R3 R4 R7: valid exactly at the aligned slot
      check(rvalid_o == expv, "R7", {name, " rvalid"}, 32'(rvalid_o), 32'(expv));
      if (expv) begin
        for (int d = 0; d < NDEV; d++) expw[d*DW +: DW] = pat(t, d);
        // R2 R8: aligned word, lane 0 in the low bits
        check(rdata_o == expw, fixed ? "R4" : "R3", {name, " rdata (R2 R8)"},
              32'(rdata_o), 32'(expw));
        lastw = expw;
      end else begin
        check(rdata_o == lastw, "R11", {name, " hold"}, 32'(rdata_o), 32'(lastw));
      end
      @(negedge clk);
    end
    wvalid_i = '0;
    check(lat_ok_o == exp_ok && spread_err_o == exp_err, "R9", {name, " flags kept"},
          32'({lat_ok_o, spread_err_o}), 32'({exp_ok, exp_err}));
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!rvalid_o, "R1", "rvalid after reset", 32'(rvalid_o), 0);
    check(!lat_ok_o && !spread_err_o, "R1", "flags after reset",
          32'({lat_ok_o, spread_err_o}), 0);
    check(rdata_o == '0, "R1", "rdata after reset", 32'(rdata_o), 0);
  endtask

  task automatic test_no_load();
    wvalid_i = '1;
    wdata_i = 24'h5a_a5_3c;
    for (int i = 0; i < DEPTH + 4; i++) begin
      @(negedge clk);
      check(!rvalid_o, "R10", "rvalid before load", 32'(rvalid_o), 0);
    end
    wvalid_i = '0;
  endtask

  initial begin
    test_reset();
    test_no_load();
    run_case("auto_equal",      1'b0, 0,  4, 4, 4, -1, 1'b0, 1'b0);
    run_case("auto_spread2",    1'b0, 0,  5, 7, 6, -1, 1'b0, 1'b0);
    run_case("auto_spread3",    1'b0, 0,  3, 6, 4, -1, 1'b0, 1'b1);
    run_case("fixed_at_max",    1'b1, 7,  5, 7, 6, -1, 1'b1, 1'b0);
    run_case("fixed_below_max", 1'b1, 6,  5, 7, 6, -1, 1'b0, 1'b0);
    run_case("fixed_reach7",    1'b1, 12, 5, 7, 6, -1, 1'b1, 1'b0);
    run_case("fixed_reach8",    1'b1, 13, 5, 7, 6, -1, 1'b0, 1'b0);
    run_case("fixed_wide",      1'b1, 9,  2, 7, 4, -1, 1'b1, 1'b0);
    run_case("auto_drop_lane1", 1'b0, 0,  2, 3, 2, 5,  1'b0, 1'b0);
    finish_run();
  end

endmodule